// File: doc/BRIEF.md
# Bidirectional Sampling-Strobe Sequencer

This block produces the sampling strobes for a column driver that captures three video lanes at once. A single start pulse enters a one-hot chain of 100 stages and moves one stage per rising clock edge. Each stage drives a group of three adjacent channel strobes, so the 300 channels are swept 3 at a time. A direction input selects whether the sweep runs from channel 1 upward or from channel 300 downward. The two cascade pins swap roles with the direction: one pin takes the start pulse and the other passes a carry to the next driver in the chain.

A reduced mode shortens the sweep to 96 stages by skipping the four middle stages (channels 145 to 156). Those channels are not swept on their own. They repeat the strobes of the four-stage group on the side the sweep reaches them from: channels 157 to 168 for an upward sweep and channels 133 to 144 for a downward sweep. A bank input selects which of two downstream hold banks samples and which one drives. A test input must stay low for normal operation. While it is high, the chain is held empty.

Top module: `sample_strobe_seq`

## Requirements
- R1: Bit 3s+l of `strobe_o` is the strobe for channel 3s+l+1, which lane l+1 feeds (s = 0..99, l = 0..2). The three bits of one stage always switch together.
- R2: The selected start pin is sampled on each rising clock edge. The first stage's strobe goes high in the cycle that follows the edge that first samples the pin high. A start pulse held high for several cycles starts exactly one sweep and does not delay that strobe.
- R3: After it starts, the active stage advances by exactly one stage per clock edge. Each stage is high for one cycle. In full mode, at most one stage (three strobe bits) is high at a time.
- R4: With `dir_right_i` = 1, `casc_r_i` is the start pin, the sweep runs from stage 0 to stage 99, and `casc_l_o` is driven (`casc_l_oe_o` = 1, `casc_r_oe_o` = 0). With `dir_right_i` = 0 these roles mirror: `casc_l_i` is the start pin and the sweep runs from stage 99 to stage 0. A pin that is not driven outputs 0.
- R5: The outgoing cascade pin is high for exactly the one cycle in which the last stage of the sweep strobes. That is 99 edges after the start edge in full mode, so a downstream block that samples the pin starts 100 edges after this one.
- R6: With `full_mode_i` = 0, stages 48..51 (channels 145..156) are skipped. The sweep has 96 stages, and the carry comes 95 edges after the start edge.
- R7: With `full_mode_i` = 0, skipped stage b drives the same strobe as stage b+4 when `dir_right_i` = 1, and as stage b-4 when `dir_right_i` = 0.
- R8: A new rising edge on the start pin during a sweep cancels that sweep and restarts it from the first stage.
- R9: While `test_i` is 1, all strobes and both cascade outputs are 0 on the next cycle, and no start is accepted.
- R10: `bank1_sample_o` = `bank_sel_i` and `bank2_sample_o` = not `bank_sel_i`. A bank that is not sampling is driving.
- R11: An asynchronous active-low reset `rst_ni` clears every stage and the start history. All strobes and both cascade outputs are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_right_i | input | 1 | 1 = sweep upward from channel 1, 0 = sweep downward from channel 300 |
| full_mode_i | input | 1 | 1 = 100 stages, 0 = 96 stages with middle mirroring |
| bank_sel_i | input | 1 | Hold-bank role select |
| test_i | input | 1 | Must be 0 in operation; 1 holds the chain empty |
| casc_r_i | input | 1 | Right cascade pin, input side |
| casc_l_i | input | 1 | Left cascade pin, input side |
| casc_r_o | output | 1 | Right cascade pin, carry output |
| casc_r_oe_o | output | 1 | Right cascade pin drive enable |
| casc_l_o | output | 1 | Left cascade pin, carry output |
| casc_l_oe_o | output | 1 | Left cascade pin drive enable |
| strobe_o | output | 300 | Channel sampling strobes |
| bank1_sample_o | output | 1 | Hold bank 1 samples (bank 2 drives) |
| bank2_sample_o | output | 1 | Hold bank 2 samples (bank 1 drives) |

## Verification
An extra or lost bit in the one-hot chain shows at `strobe_o` on the very next cycle, as a second lit group or as a missing group. A wrong skip link across the middle, or a wrong mirror source, first shows in the cycle the sweep reaches stage 47 or stage 52. A chain that is shorter or longer than it should be only shows late, when the carry pin fires one cycle early or late at the end of the sweep. For that reason the bench compares every output on every clock against a position-counting model, and it also measures the start-to-carry distance directly.

// File: rtl/sample_strobe_pkg.sv
package sample_strobe_pkg;
  typedef enum logic {
    SCAN_LEFT  = 1'b0,
    SCAN_RIGHT = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/strobe_start_edge.sv
module strobe_start_edge
  import sample_strobe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  scan_dir_e dir_i,
  input  logic      casc_r_i,
  input  logic      casc_l_i,
  output logic      load_o
);
  logic sel, seen_q;

  assign sel = (dir_i == SCAN_RIGHT) ? casc_r_i : casc_l_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= sel;
  end

  // only the first sampled high level starts a sweep
  assign load_o = sel & ~seen_q;
endmodule

// File: rtl/strobe_stage_chain.sv
module strobe_stage_chain
  import sample_strobe_pkg::*;
#(
  parameter int N_STAGES = 100,
  parameter int BYP_LO   = 48,
  parameter int BYP_N    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  scan_dir_e           dir_i,
  input  logic                full_mode_i,
  input  logic                test_i,
  input  logic                load_i,
  output logic [N_STAGES-1:0] stage_q_o
);
  localparam int BYP_HI = BYP_LO + BYP_N - 1;

  logic [N_STAGES-1:0] q, d;
  logic                dir_r;

  assign dir_r = (dir_i == SCAN_RIGHT);

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    localparam bit FIRST_R = (s == 0);
    localparam bit FIRST_L = (s == N_STAGES - 1);
    logic from_r, from_l, skip;

    if (s == 0) begin : g_r_edge
      assign from_r = 1'b0;
    end else if (s == BYP_HI + 1) begin : g_r_jump
      assign from_r = full_mode_i ? q[s-1] : q[BYP_LO-1];
    end else begin : g_r_plain
      assign from_r = q[s-1];
    end

    if (s == N_STAGES - 1) begin : g_l_edge
      assign from_l = 1'b0;
    end else if (s == BYP_LO - 1) begin : g_l_jump
      assign from_l = full_mode_i ? q[s+1] : q[BYP_HI+1];
    end else begin : g_l_plain
      assign from_l = q[s+1];
    end

    if (s >= BYP_LO && s <= BYP_HI) begin : g_byp
      assign skip = ~full_mode_i;
    end else begin : g_nobyp
      assign skip = 1'b0;
    end

    assign d[s] = test_i ? 1'b0 :
                  load_i ? (dir_r ? FIRST_R : FIRST_L) :
                  skip   ? 1'b0 :
                  dir_r  ? from_r : from_l;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign stage_q_o = q;
endmodule

// File: rtl/strobe_fanout.sv
module strobe_fanout
  import sample_strobe_pkg::*;
#(
  parameter int N_STAGES = 100,
  parameter int LANES    = 3,
  parameter int BYP_LO   = 48,
  parameter int BYP_N    = 4,
  localparam int N_CH    = N_STAGES * LANES
) (
  input  logic [N_STAGES-1:0] stage_i,
  input  scan_dir_e           dir_i,
  input  logic                full_mode_i,
  output logic [N_CH-1:0]     strobe_o
);
  localparam int BYP_HI = BYP_LO + BYP_N - 1;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_grp
    logic grp;
    if (s >= BYP_LO && s <= BYP_HI) begin : g_mirror
      assign grp = full_mode_i ? stage_i[s] :
                   (dir_i == SCAN_RIGHT) ? stage_i[s+BYP_N] : stage_i[s-BYP_N];
    end else begin : g_direct
      assign grp = stage_i[s];
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign strobe_o[s*LANES+l] = grp;
    end
  end
endmodule

// File: rtl/strobe_edge_io.sv
module strobe_edge_io
  import sample_strobe_pkg::*;
(
  input  scan_dir_e dir_i,
  input  logic      last_up_i,
  input  logic      last_dn_i,
  input  logic      bank_sel_i,
  output logic      casc_r_o,
  output logic      casc_r_oe_o,
  output logic      casc_l_o,
  output logic      casc_l_oe_o,
  output logic      bank1_sample_o,
  output logic      bank2_sample_o
);
  logic up;
  assign up = (dir_i == SCAN_RIGHT);

  // the pin not used as start input carries the end-of-sweep flag
  assign casc_l_oe_o = up;
  assign casc_l_o    = up & last_up_i;
  assign casc_r_oe_o = ~up;
  assign casc_r_o    = ~up & last_dn_i;

  assign bank1_sample_o = bank_sel_i;
  assign bank2_sample_o = ~bank_sel_i;
endmodule

// File: rtl/sample_strobe_seq.sv
module sample_strobe_seq
  import sample_strobe_pkg::*;
#(
  parameter int N_STAGES = 100,
  parameter int LANES    = 3,
  parameter int BYP_LO   = 48,
  parameter int BYP_N    = 4,
  localparam int N_CH    = N_STAGES * LANES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_right_i,
  input  logic            full_mode_i,
  input  logic            bank_sel_i,
  input  logic            test_i,
  input  logic            casc_r_i,
  input  logic            casc_l_i,
  output logic            casc_r_o,
  output logic            casc_r_oe_o,
  output logic            casc_l_o,
  output logic            casc_l_oe_o,
  output logic [N_CH-1:0] strobe_o,
  output logic            bank1_sample_o,
  output logic            bank2_sample_o
);
  scan_dir_e           dir;
  logic                load;
  logic [N_STAGES-1:0] stage_q;

  assign dir = dir_right_i ? SCAN_RIGHT : SCAN_LEFT;

  strobe_start_edge i_start (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dir_i    (dir),
    .casc_r_i (casc_r_i),
    .casc_l_i (casc_l_i),
    .load_o   (load)
  );

  strobe_stage_chain #(
    .N_STAGES (N_STAGES),
    .BYP_LO   (BYP_LO),
    .BYP_N    (BYP_N)
  ) i_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (dir),
    .full_mode_i (full_mode_i),
    .test_i      (test_i),
    .load_i      (load),
    .stage_q_o   (stage_q)
  );

  strobe_fanout #(
    .N_STAGES (N_STAGES),
    .LANES    (LANES),
    .BYP_LO   (BYP_LO),
    .BYP_N    (BYP_N)
  ) i_fanout (
    .stage_i     (stage_q),
    .dir_i       (dir),
    .full_mode_i (full_mode_i),
    .strobe_o    (strobe_o)
  );

  strobe_edge_io i_io (
    .dir_i          (dir),
    .last_up_i      (stage_q[N_STAGES-1]),
    .last_dn_i      (stage_q[0]),
    .bank_sel_i     (bank_sel_i),
    .casc_r_o       (casc_r_o),
    .casc_r_oe_o    (casc_r_oe_o),
    .casc_l_o       (casc_l_o),
    .casc_l_oe_o    (casc_l_oe_o),
    .bank1_sample_o (bank1_sample_o),
    .bank2_sample_o (bank2_sample_o)
  );
endmodule

// File: rtl/sample_strobe_seq_chk.sv
module sample_strobe_seq_chk #(
  parameter int N_STAGES = 100,
  parameter int LANES    = 3,
  parameter int BYP_LO   = 48,
  parameter int BYP_N    = 4,
  localparam int N_CH    = N_STAGES * LANES
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dir_right_i,
  input logic            full_mode_i,
  input logic            test_i,
  input logic            casc_r_i,
  input logic            casc_l_i,
  input logic            casc_r_o,
  input logic            casc_r_oe_o,
  input logic            casc_l_o,
  input logic            casc_l_oe_o,
  input logic [N_CH-1:0] strobe_o
);
  p_step_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_right_i && !test_i && !casc_r_i && strobe_o[0]) |=> strobe_o[LANES]);

  p_step_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_right_i && !test_i && !casc_l_i && strobe_o[N_CH-1]) |=> strobe_o[N_CH-1-LANES]);

  p_single_stage_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_mode_i |-> ($countones(strobe_o) <= LANES));

  p_mirror_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_mode_i |-> (strobe_o[BYP_LO*LANES] ==
      (dir_right_i ? strobe_o[(BYP_LO+BYP_N)*LANES] : strobe_o[(BYP_LO-BYP_N)*LANES])));

  p_carry_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_l_o |-> (dir_right_i && strobe_o[N_CH-1]));

  p_carry_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    casc_r_o |-> (!dir_right_i && strobe_o[0]));

  p_idle_pin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!casc_r_oe_o -> !casc_r_o) && (!casc_l_oe_o -> !casc_l_o)));

  p_test_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> (strobe_o == '0 && !casc_l_o && !casc_r_o));
endmodule

bind sample_strobe_seq sample_strobe_seq_chk #(
  .N_STAGES (N_STAGES),
  .LANES    (LANES),
  .BYP_LO   (BYP_LO),
  .BYP_N    (BYP_N)
) i_chk (.*);

// File: tb/test_sample_strobe_seq.sv
`timescale 1ns/1ps
module test_sample_strobe_seq;
  localparam int NS = 100, LN = 3, BL = 48, BN = 4, NCH = NS * LN;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dir_right_i = 1'b1, full_mode_i = 1'b1, bank_sel_i = 1'b0, test_i = 1'b0;
  logic casc_r_i = 1'b0, casc_l_i = 1'b0;
  logic casc_r_o, casc_r_oe_o, casc_l_o, casc_l_oe_o, bank1_sample_o, bank2_sample_o;
  logic [NCH-1:0] strobe_o;

  sample_strobe_seq i_sample_strobe_seq (.*);

  always #2 clk_i = ~clk_i;

  int vectors = 0, fails = 0, tcount = 0;
  int pos = -1, load_tick = -1, carry_tick = -1;
  bit sprev = 1'b0;
  string cur_req = "R11";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int sweep_len();
    return full_mode_i ? NS : NS - BN;
  endfunction

  function automatic int stage_of(input int p);
    if (dir_right_i) return (full_mode_i || p < BL) ? p : p + BN;
    return (full_mode_i || p < BL) ? NS - 1 - p : NS - 1 - p - BN;
  endfunction

  function automatic logic [NCH-1:0] exp_strobe();
    logic [NCH-1:0] v = '0;
    if (pos >= 0) begin
      int s = stage_of(pos);
      for (int l = 0; l < LN; l++) v[s*LN+l] = 1'b1;
      if (!full_mode_i)
        for (int b = BL; b < BL + BN; b++)
          if ((dir_right_i ? b + BN : b - BN) == s)
            for (int l = 0; l < LN; l++) v[b*LN+l] = 1'b1;
    end
    return v;
  endfunction

  task automatic tick();
    logic [NCH-1:0] es;
    logic [3:0] ep, ap;
    int s;
    bit sel;
    @(posedge clk_i);
    tcount++;
    if (!rst_ni) begin
      pos = -1; sprev = 1'b0;
    end else begin
      sel = dir_right_i ? casc_r_i : casc_l_i;
      if (test_i) pos = -1;
      else if (sel && !sprev) begin pos = 0; load_tick = tcount; end
      else if (pos >= 0) begin
        pos++;
        if (pos >= sweep_len()) pos = -1;
      end
      sprev = sel;
    end
    #1;
    es = exp_strobe();
    s = (pos >= 0) ? stage_of(pos) : -1;
    ep = {dir_right_i && s == NS - 1, dir_right_i, !dir_right_i && s == 0, !dir_right_i};
    ap = {casc_l_o, casc_l_oe_o, casc_r_o, casc_r_oe_o};
    check(strobe_o === es, cur_req, "strobes", strobe_o, es);
    check(ap === ep, cur_req, "cascade pins {l,l_oe,r,r_oe}", NCH'(ap), NCH'(ep));
    check({bank1_sample_o, bank2_sample_o} === {bank_sel_i, !bank_sel_i}, "R10", "bank roles",
          NCH'({bank1_sample_o, bank2_sample_o}), NCH'({bank_sel_i, !bank_sel_i}));
    if ((casc_l_o || casc_r_o) && carry_tick < 0) carry_tick = tcount;
  endtask

  task automatic drive_start(input bit v);
    if (dir_right_i) casc_r_i = v; else casc_l_i = v;
  endtask

  task automatic sweep(input bit dir, input bit full, input int width, input string req);
    dir_right_i = dir; full_mode_i = full; cur_req = req;
    repeat (2) tick();
    carry_tick = -1;
    drive_start(1'b1);
    repeat (width) tick();
    drive_start(1'b0);
    repeat (sweep_len() + 3) tick();
    check(carry_tick - load_tick == sweep_len() - 1, full ? "R5" : "R6", "start-to-carry edges",
          NCH'(carry_tick - load_tick), NCH'(sweep_len() - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) tick();
    check(strobe_o === '0, "R11", "strobes in reset", strobe_o, '0);
    @(negedge clk_i) rst_ni = 1'b1;
    tick();
    // R10 bank select both ways
    cur_req = "R10";
    bank_sel_i = 1'b1; tick();
    bank_sel_i = 1'b0; tick();
    // R2/R3/R4 upward single-cycle pulse, R1 group check mid-sweep
    sweep(1'b1, 1'b1, 1, "R3");
    dir_right_i = 1'b1; cur_req = "R1";
    drive_start(1'b1); tick(); drive_start(1'b0);
    repeat (10) tick();
    begin
      int bad = 0;
      for (int s = 0; s < NS; s++)
        if (strobe_o[s*LN+:LN] != '0 && strobe_o[s*LN+:LN] != '1) bad++;
      check(bad == 0, "R1", "lanes of one stage differ", NCH'(bad), '0);
    end
    repeat (NS) tick();
    // R2 wide start pulse
    sweep(1'b1, 1'b1, 4, "R2");
    // R4 downward sweep
    sweep(1'b0, 1'b1, 1, "R4");
    // R6/R7 reduced sweeps both directions
    sweep(1'b1, 1'b0, 1, "R7");
    sweep(1'b0, 1'b0, 2, "R7");
    // R8 restart mid-sweep
    dir_right_i = 1'b1; full_mode_i = 1'b1; cur_req = "R8";
    drive_start(1'b1); tick(); drive_start(1'b0);
    repeat (20) tick();
    drive_start(1'b1); tick(); drive_start(1'b0);
    check(strobe_o[LN-1:0] === '1 && strobe_o[NCH-1:LN] === '0, "R8", "restart at stage 0",
          strobe_o, NCH'(3'b111));
    repeat (NS + 2) tick();
    // R9 test input
    cur_req = "R9";
    drive_start(1'b1); tick(); drive_start(1'b0);
    repeat (5) tick();
    test_i = 1'b1; tick();
    check(strobe_o === '0, "R9", "chain cleared by test", strobe_o, '0);
    drive_start(1'b1); repeat (3) tick();
    test_i = 1'b0; repeat (4) tick();
    drive_start(1'b0); repeat (3) tick();
    // R11 reset mid-sweep
    cur_req = "R11";
    dir_right_i = 1'b0;
    drive_start(1'b1); tick(); drive_start(1'b0);
    repeat (8) tick();
    @(negedge clk_i) rst_ni = 1'b0;
    #1 check(strobe_o === '0 && !casc_r_o, "R11", "async clear", strobe_o, '0);
    tick();
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule